// File: doc/BRIEF.md
# Omega Self-Routing Switch Network

This block is an N-port multistage interconnect made of 2x2 switch elements. Every input port may present a packet in any cycle. A packet is a valid flag, a destination port index and a data word. The network has log2(N) stages. Before each stage, the line indices are permuted by a perfect shuffle, which rotates the index bits one place to the left. Each stage then steers every packet with one bit of that packet's destination. The network needs no central controller: each switch sets itself from the packets that reach it.

Only one path joins any input to any output, so two packets can ask for the same switch output in the same cycle. The packet on the switch's upper line wins that output. The other packet is dropped, and the input port it came from is flagged as blocked. Each delivered packet is tagged with the index of its source port.

Inputs are captured in one register stage and results leave through a second register stage. The switching fabric between the two is combinational.

Top module: `omega_net`

## Requirements
- R1: While rst_ni is low, and after it is released with no input valid, every out_valid_o bit and every blocked_o bit is 0.
- R2: A packet sampled at a rising edge (edge k) is visible on the outputs after edge k+1. Between edge k and edge k+1 the outputs still show the previous result.
- R3: A packet that meets no conflict appears on the output port whose index equals its destination, with its data word unchanged.
- R4: out_src_o for a valid output port holds the index of the input port that the packet entered on. The index is ADDR_W bits wide, at bits [j*ADDR_W +: ADDR_W] for output j.
- R5: The upper line of a switch has priority. The shuffle maps line b2b1b0 to b1b0b2, and switch k takes line 2k as its upper input and line 2k+1 as its lower input. Example: inputs 0 and 4 meet at stage 0 with input 0 on the upper line, and input 0 wins. Example: inputs 0 and 2 meet at stage 1 with input 0 on the upper line, and input 0 wins. A lower-line packet whose upper line is idle, or which asks for the other output, passes through.
- R6: If a valid packet loses a conflict, it is not delivered anywhere, and blocked_o[src] is 1 in the same cycle that the outputs for that packet's batch appear.
- R7: A conflict-free set of packets is delivered completely, with all blocked_o bits 0. The identity mapping and the cyclic shift dest = (src + 3) mod N are both conflict-free.
- R8: An input whose in_valid_i bit is 0 is ignored. Its destination and data do not produce an output and do not set a blocked flag.
- R9: Packets presented in consecutive cycles are delivered in consecutive cycles, each two edges after it was presented. One batch does not affect another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | N_PORTS | Per-input packet valid |
| in_dest_i | input | N_PORTS*ADDR_W | Per-input destination index, port i at [i*ADDR_W +: ADDR_W] |
| in_data_i | input | N_PORTS*DATA_W | Per-input data word, port i at [i*DATA_W +: DATA_W] |
| out_valid_o | output | N_PORTS | Per-output packet valid |
| out_src_o | output | N_PORTS*ADDR_W | Source input index of the packet on each output |
| out_data_o | output | N_PORTS*DATA_W | Data word on each output |
| blocked_o | output | N_PORTS | Per-input flag: that input's packet lost a conflict |

## Verification
A batch is captured at the first rising edge after it is driven. Its routed result, including the blocked flags, is registered at the next edge. The bench drives inputs on falling edges. It checks at the falling edge after the capture edge that the outputs are still empty, and removes the stimulus there. It reads the full result at the falling edge after the second rising edge. For back-to-back batches, the bench samples one falling edge apart, so each batch is compared in the cycle it is due, and a packet that is one cycle early or late shows up as an error.

// File: rtl/omega_pkg.sv
package omega_pkg;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_UPPER,
    SEL_LOWER
  } sel_e;

  // perfect shuffle: rotate index bits left by one
  function automatic int unsigned shuffle_idx(int unsigned idx, int unsigned bits);
    int unsigned mask;
    mask = (1 << bits) - 1;
    return ((idx << 1) | (idx >> (bits - 1))) & mask;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch
  import omega_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16,
  parameter int BIT_POS = 2,
  localparam int PKT_W  = 1 + 2 * ADDR_W + DATA_W
) (
  input  logic [PKT_W-1:0]  up_i,
  input  logic [PKT_W-1:0]  lo_i,
  output logic [PKT_W-1:0]  up_o,
  output logic [PKT_W-1:0]  lo_o,
  output logic              drop_o,
  output logic [ADDR_W-1:0] drop_src_o
);

  localparam int VLD_POS  = PKT_W - 1;
  localparam int DBIT_POS = DATA_W + ADDR_W + BIT_POS;

  logic up_v, lo_v, up_b, lo_b;
  sel_e sel_up, sel_lo;

  assign up_v = up_i[VLD_POS];
  assign lo_v = lo_i[VLD_POS];
  assign up_b = up_i[DBIT_POS];
  assign lo_b = lo_i[DBIT_POS];

  always_comb begin
    sel_up = SEL_NONE;
    if (up_v && !up_b)      sel_up = SEL_UPPER;
    else if (lo_v && !lo_b) sel_up = SEL_LOWER;
    sel_lo = SEL_NONE;
    if (up_v && up_b)       sel_lo = SEL_UPPER;
    else if (lo_v && lo_b)  sel_lo = SEL_LOWER;
  end

  always_comb begin
    unique case (sel_up)
      SEL_UPPER: up_o = up_i;
      SEL_LOWER: up_o = lo_i;
      default:   up_o = '0;
    endcase
    unique case (sel_lo)
      SEL_UPPER: lo_o = up_i;
      SEL_LOWER: lo_o = lo_i;
      default:   lo_o = '0;
    endcase
  end

  // lower line loses when both ask for the same output
  assign drop_o     = up_v && lo_v && (up_b == lo_b);
  assign drop_src_o = lo_i[DATA_W +: ADDR_W];

  always_comb begin
    AST_SW_CONSERVE: assert ($countones({up_o[VLD_POS], lo_o[VLD_POS], drop_o})
                             == $countones({up_v, lo_v})); // R6
    if (drop_o) begin
      AST_SW_UPPER_WINS: assert ((up_b ? sel_lo : sel_up) == SEL_UPPER); // R5
    end
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
  import omega_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 16,
  parameter int STAGE   = 0,
  localparam int ADDR_W = $clog2(N_PORTS),
  localparam int PKT_W  = 1 + 2 * ADDR_W + DATA_W,
  localparam int N_SW   = N_PORTS / 2
) (
  input  logic [PKT_W-1:0]   lines_i [N_PORTS],
  output logic [PKT_W-1:0]   lines_o [N_PORTS],
  output logic [N_PORTS-1:0] drop_mask_o
);

  localparam int BIT_POS = ADDR_W - 1 - STAGE;

  logic [PKT_W-1:0]  shuf [N_PORTS];
  logic [N_SW-1:0]   drop;
  logic [ADDR_W-1:0] drop_src [N_SW];

  for (genvar i = 0; i < N_PORTS; i++) begin : g_shuf
    assign shuf[shuffle_idx(i, ADDR_W)] = lines_i[i];
  end

  for (genvar k = 0; k < N_SW; k++) begin : g_sw
    omega_switch #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BIT_POS(BIT_POS)
    ) i_switch (
      .up_i      (shuf[2*k]),
      .lo_i      (shuf[2*k+1]),
      .up_o      (lines_o[2*k]),
      .lo_o      (lines_o[2*k+1]),
      .drop_o    (drop[k]),
      .drop_src_o(drop_src[k])
    );
  end

  always_comb begin
    drop_mask_o = '0;
    for (int k = 0; k < N_SW; k++) begin
      if (drop[k]) drop_mask_o[drop_src[k]] = 1'b1;
    end
  end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 16,
  localparam int ADDR_W = $clog2(N_PORTS),
  localparam int STAGES = ADDR_W,
  localparam int PKT_W  = 1 + 2 * ADDR_W + DATA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_PORTS-1:0]         in_valid_i,
  input  logic [N_PORTS*ADDR_W-1:0]  in_dest_i,
  input  logic [N_PORTS*DATA_W-1:0]  in_data_i,
  output logic [N_PORTS-1:0]         out_valid_o,
  output logic [N_PORTS*ADDR_W-1:0]  out_src_o,
  output logic [N_PORTS*DATA_W-1:0]  out_data_o,
  output logic [N_PORTS-1:0]         blocked_o
);

  logic [PKT_W-1:0]   lines [STAGES+1][N_PORTS];
  logic [N_PORTS-1:0] masks [STAGES];
  logic [PKT_W-1:0]   in_q  [N_PORTS];
  logic [PKT_W-1:0]   out_q [N_PORTS];
  logic [N_PORTS-1:0] blocked_d, blocked_q, valid_q;
  logic [ADDR_W-1:0]  out_dest [N_PORTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_PORTS; i++) in_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_PORTS; i++) begin
        in_q[i] <= {in_valid_i[i], in_dest_i[i*ADDR_W +: ADDR_W],
                    ADDR_W'(i), in_data_i[i*DATA_W +: DATA_W]};
      end
    end
  end

  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    assign lines[0][i] = in_q[i];
    assign valid_q[i]  = in_q[i][PKT_W-1];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    omega_stage #(
      .N_PORTS(N_PORTS),
      .DATA_W (DATA_W),
      .STAGE  (s)
    ) i_stage (
      .lines_i    (lines[s]),
      .lines_o    (lines[s+1]),
      .drop_mask_o(masks[s])
    );
  end

  always_comb begin
    blocked_d = '0;
    for (int s = 0; s < STAGES; s++) blocked_d |= masks[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < N_PORTS; j++) out_q[j] <= '0;
      blocked_q <= '0;
    end else begin
      for (int j = 0; j < N_PORTS; j++) out_q[j] <= lines[STAGES][j];
      blocked_q <= blocked_d;
    end
  end

  for (genvar j = 0; j < N_PORTS; j++) begin : g_out
    assign out_valid_o[j]                     = out_q[j][PKT_W-1];
    assign out_dest[j]                        = out_q[j][DATA_W+ADDR_W +: ADDR_W];
    assign out_src_o[j*ADDR_W +: ADDR_W]      = out_q[j][DATA_W +: ADDR_W];
    assign out_data_o[j*DATA_W +: DATA_W]     = out_q[j][DATA_W-1:0];

    AST_DEST_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[j] |-> (out_dest[j] == ADDR_W'(j))); // R3

    AST_BLOCKED_HAD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blocked_o[j] |-> $past(in_valid_i[j], 2)); // R6
  end

  assign blocked_o = blocked_q;

  AST_CONSERVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(out_valid_o) + $countones(blocked_o)
              == $countones($past(valid_q)))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q == '0) |=> (out_valid_o == '0 && blocked_o == '0)); // R8

  AST_PROGRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q != '0) |=> (out_valid_o != '0)); // R2

endmodule

// File: tb/test_omega_net.sv
`timescale 1ns/1ps
module test_omega_net;

  localparam int N  = 8;
  localparam int AW = 3;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    in_valid = '0;
  logic [N*AW-1:0] in_dest = '0;
  logic [N*DW-1:0] in_data = '0;
  logic [N-1:0]    out_valid;
  logic [N*AW-1:0] out_src;
  logic [N*DW-1:0] out_data;
  logic [N-1:0]    blocked;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  omega_net #(.N_PORTS(N), .DATA_W(DW)) i_omega_net (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_dest_i  (in_dest),
    .in_data_i  (in_data),
    .out_valid_o(out_valid),
    .out_src_o  (out_src),
    .out_data_o (out_data),
    .blocked_o  (blocked)
  );

  function automatic logic [DW-1:0] pat(int tid, int i);
    return DW'(tid * 256 + i * 17 + 3);
  endfunction

  task automatic check(string rq, bit ok, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic drive(logic [N-1:0] v, logic [N*AW-1:0] d, int tid);
    in_valid = v;
    in_dest  = d;
    for (int i = 0; i < N; i++) in_data[i*DW +: DW] = pat(tid, i);
  endtask

  task automatic expect_port(string rq, int j, bit ev, int esrc, int tid);
    check({rq, " valid"}, out_valid[j] == ev, out_valid[j], ev);
    if (ev) begin
      check({rq, " src"}, out_src[j*AW +: AW] == AW'(esrc), out_src[j*AW +: AW], esrc);
      check({rq, " data"}, out_data[j*DW +: DW] == pat(tid, esrc),
            out_data[j*DW +: DW], pat(tid, esrc));
    end
  endtask

  // drive on a falling edge, capture, confirm no early result, read result
  task automatic one_shot(logic [N-1:0] v, logic [N*AW-1:0] d, int tid);
    @(negedge clk);
    drive(v, d, tid);
    @(posedge clk);
    @(negedge clk);
    check("R2 not early", out_valid == '0 && blocked == '0, {out_valid, blocked}, 0);
    drive('0, '0, 0);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 valid in reset", out_valid == '0, out_valid, 0);
    check("R1 blocked in reset", blocked == '0, blocked, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", out_valid == '0, out_valid, 0);
    check("R1 blocked after reset", blocked == '0, blocked, 0);
  endtask

  task automatic t_identity();
    logic [N*AW-1:0] d;
    for (int i = 0; i < N; i++) d[i*AW +: AW] = AW'(i);
    one_shot('1, d, 1);
    for (int j = 0; j < N; j++) expect_port("R3 R4 R7 identity", j, 1'b1, j, 1);
    check("R7 identity none blocked", blocked == '0, blocked, 0);
  endtask

  task automatic t_shift();
    logic [N*AW-1:0] d;
    for (int i = 0; i < N; i++) d[i*AW +: AW] = AW'((i + 3) % N);
    one_shot('1, d, 2);
    for (int j = 0; j < N; j++) expect_port("R3 R4 R7 shift", j, 1'b1, (j + N - 3) % N, 2);
    check("R7 shift none blocked", blocked == '0, blocked, 0);
  endtask

  task automatic t_conflict_s0();
    logic [N*AW-1:0] d = '0;
    d[0*AW +: AW] = 3'd0;
    d[4*AW +: AW] = 3'd1;
    one_shot(8'h11, d, 3);
    expect_port("R5 stage0 winner", 0, 1'b1, 0, 3);
    expect_port("R6 stage0 loser not delivered", 1, 1'b0, 0, 3);
    check("R6 stage0 blocked", blocked == 8'h10, blocked, 8'h10);
  endtask

  task automatic t_priority_swap();
    logic [N*AW-1:0] d = '0;
    d[0*AW +: AW] = 3'd1;
    d[4*AW +: AW] = 3'd0;
    one_shot(8'h11, d, 4);
    expect_port("R5 upper wins swapped", 1, 1'b1, 0, 4);
    expect_port("R6 swapped loser absent", 0, 1'b0, 0, 4);
    check("R6 swapped blocked", blocked == 8'h10, blocked, 8'h10);
  endtask

  task automatic t_conflict_s1();
    logic [N*AW-1:0] d = '0;
    d[0*AW +: AW] = 3'd0;
    d[2*AW +: AW] = 3'd1;
    one_shot(8'h05, d, 5);
    expect_port("R5 stage1 winner", 0, 1'b1, 0, 5);
    expect_port("R6 stage1 loser absent", 1, 1'b0, 0, 5);
    check("R6 stage1 blocked", blocked == 8'h04, blocked, 8'h04);
  endtask

  task automatic t_lower_alone();
    logic [N*AW-1:0] d = '0;
    d[4*AW +: AW] = 3'd1;
    one_shot(8'h10, d, 6);
    expect_port("R5 lower passes", 1, 1'b1, 4, 6);
    check("R5 lower not blocked", blocked == '0, blocked, 0);
  endtask

  task automatic t_invalid();
    logic [N*AW-1:0] d;
    for (int i = 0; i < N; i++) d[i*AW +: AW] = AW'(N - 1 - i);
    one_shot('0, d, 7);
    check("R8 no output", out_valid == '0, out_valid, 0);
    check("R8 no blocked", blocked == '0, blocked, 0);
  endtask

  task automatic t_stream();
    logic [N*AW-1:0] da = '0;
    logic [N*AW-1:0] db = '0;
    da[3*AW +: AW] = 3'd5;
    db[6*AW +: AW] = 3'd2;
    @(negedge clk);
    drive(8'h08, da, 8);
    @(posedge clk);
    @(negedge clk);
    drive(8'h40, db, 9);
    @(posedge clk);
    @(negedge clk);
    drive('0, '0, 0);
    expect_port("R9 first batch", 5, 1'b1, 3, 8);
    check("R9 first batch only", out_valid == 8'h20, out_valid, 8'h20);
    @(posedge clk);
    @(negedge clk);
    expect_port("R9 second batch", 2, 1'b1, 6, 9);
    check("R9 second batch only", out_valid == 8'h04, out_valid, 8'h04);
    @(posedge clk);
    @(negedge clk);
    check("R9 drained", out_valid == '0, out_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_identity();
    t_shift();
    t_conflict_s0();
    t_priority_swap();
    t_conflict_s1();
    t_lower_alone();
    t_invalid();
    t_stream();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule